// File: doc/BRIEF.md
# Ethernet Transmit Buffer with Start Watermark

This block sits on the transmit path between a memory-read engine and a media-independent-interface serializer. The read engine pushes 32-bit words into a byte-wide FIFO, one word per cycle when there is room. The last word of a frame may carry one to four valid bytes. On the line side, the block turns the buffered bytes into nibbles, one per clock, with transmit enable held high for the length of the frame.

A frame does not start on the line side until a programmable number of bytes has collected in the FIFO. The one exception is a frame whose end marker is already buffered. If the FIFO runs dry in the middle of a frame, the block drives a one-nibble transmit error and cuts the frame short. It then discards the rest of that frame as it arrives and raises a sticky underrun event.

Software reaches four small registers: a write-one-to-clear event register, an interrupt mask, the start watermark, and the boundary that splits a shared 512-byte FIFO RAM between the receive and transmit sides.

Top module: `tx_wm_fifo`

## Requirements
- R1: After reset, mii_txen_o and mii_txer_o are 0, irq_o is 0 and wr_ready_o is 1. The event, mask and watermark registers read 0, and the boundary register reads 0x40.
- R2: Bytes of a word go out least significant byte first (wr_data_i[7:0] first). Each byte goes out as its low nibble and then its high nibble, one nibble per clock. mii_txen_o stays high with no gap from the first nibble to the last nibble of a frame.
- R3: The watermark register (address 2, bits [1:0]) sets the start level. Codes 00 and 01 mean 64 bytes, 10 means 128 and 11 means 192. With fewer bytes buffered and no end marker, mii_txen_o stays 0. Once the level is reached, the frame starts within three clocks.
- R4: A frame whose last word (wr_last_i high, wr_nb_i = valid bytes minus one) is already buffered starts even when it is shorter than the watermark.
- R5: If the FIFO is empty in the middle of a frame, the block drives one nibble with mii_txen_o=1, mii_txer_o=1 and mii_txd_o=0, and then ends the frame. The same event sets event bit 0 (underrun).
- R6: After an underrun, words written up to and including the next word with wr_last_i are accepted but dropped and never transmitted. The frame after that goes out normally.
- R7: The event register is at address 0. Writing 1 to a bit clears that bit. Writing 0 leaves the bit unchanged. A new event takes precedence over a clear in the same cycle.
- R8: irq_o is high exactly when some event bit is set and the bit in the same position of the mask register (address 1) is set.
- R9: The boundary register (address 3) holds the transmit region size in 4-byte words. Writes below 0x48 store 0x48 and writes above 0x80 store 0x80. wr_ready_o is low while fewer than 4 bytes of the transmit region are free, and the buffered count never exceeds the region.
- R10: Event bit 1 is set when the last byte of a frame has been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one nibble per cycle on the line side |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write word valid |
| wr_ready_o | output | 1 | Room for a word, or frame being dropped |
| wr_data_i | input | 32 | Write word, byte 0 in bits [7:0] |
| wr_last_i | input | 1 | Word ends the frame |
| wr_nb_i | input | 2 | Valid bytes minus one on the last word |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational on address |
| mii_txd_o | output | 4 | Transmit nibble |
| mii_txen_o | output | 1 | Transmit enable |
| mii_txer_o | output | 1 | Transmit error |
| irq_o | output | 1 | Masked event interrupt |

## Verification
The hardest condition to reach is an underrun followed by a drop phase. The FIFO has to empty exactly between two nibbles of a live frame, and the rest of that frame then has to arrive and vanish. The bench reaches this by writing exactly one watermark's worth of a longer frame and then stopping the writes. It expects the full nibble stream of those bytes followed by a single error nibble. It then writes the tail of the frame and confirms that nothing more appears on the line before a fresh frame goes out. Back-pressure from the boundary is another hard case. The bench provokes it by narrowing the transmit region and writing a frame larger than the region at full rate, and it shows the opposite outcome with the widest region.

// File: rtl/txwm_pkg.sv
package txwm_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SEND  = 2'd1,
    TX_FLUSH = 2'd2
  } tx_state_e;

  localparam logic [1:0] A_EVT  = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_WMRK = 2'd2;
  localparam logic [1:0] A_BND  = 2'd3;

  localparam int EVT_UNDERRUN = 0;
  localparam int EVT_DONE     = 1;
  localparam int EVT_W        = 2;

  function automatic int unsigned wm_bytes(logic [1:0] code);
    case (code)
      2'b10:   return 128;
      2'b11:   return 192;
      default: return 64;
    endcase
  endfunction
endpackage

// File: rtl/txwm_store.sv
module txwm_store #(
  parameter int RAM_BYTES = 512,
  parameter int LANES     = 4,
  localparam int AW = $clog2(RAM_BYTES),
  localparam int CW = $clog2(RAM_BYTES + 1),
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  logic [8*LANES-1:0] push_data_i,
  input  logic [NW-1:0]      push_n_i,
  input  logic               push_last_i,
  input  logic               pop_i,
  output logic [7:0]         head_o,
  output logic               head_last_o,
  output logic [CW-1:0]      count_o,
  output logic [CW-1:0]      frames_o
);
  logic [7:0]           mem [RAM_BYTES];
  logic [RAM_BYTES-1:0] lastv;
  logic [AW-1:0]        wptr_q, rptr_q;
  logic [CW-1:0]        count_q, frames_q;

  // lane k lands at wptr+k; only the final valid lane of an end word is marked
  always_ff @(posedge clk_i) begin
    if (push_i) begin
      for (int k = 0; k < LANES; k++) begin
        if (k < int'(push_n_i)) begin
          mem[wptr_q + AW'(k)]   <= push_data_i[8*k +: 8];
          lastv[wptr_q + AW'(k)] <= push_last_i && (k == int'(push_n_i) - 1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q   <= '0;
      rptr_q   <= '0;
      count_q  <= '0;
      frames_q <= '0;
    end else begin
      if (push_i) wptr_q <= wptr_q + AW'(push_n_i);
      if (pop_i)  rptr_q <= rptr_q + 1'b1;
      count_q  <= count_q + (push_i ? CW'(push_n_i) : CW'(0)) - CW'(pop_i);
      frames_q <= frames_q + CW'(push_i && push_last_i) - CW'(pop_i && lastv[rptr_q]);
    end
  end

  assign head_o      = mem[rptr_q];
  assign head_last_o = lastv[rptr_q];
  assign count_o     = count_q;
  assign frames_o    = frames_q;
endmodule

// File: rtl/txwm_mii_tx.sv
module txwm_mii_tx
  import txwm_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    wm_code_i,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] frames_i,
  input  logic [7:0]    head_i,
  input  logic          head_last_i,
  input  logic          wr_fire_i,
  input  logic          wr_last_i,
  output logic          pop_o,
  output logic          flush_o,
  output logic          underrun_o,
  output logic          done_o,
  output logic [3:0]    txd_o,
  output logic          txen_o,
  output logic          txer_o
);
  tx_state_e state_q, state_d;
  logic      nib_hi_q;
  logic      start_ok, underrun;
  logic      txen_q, txer_q;
  logic [3:0] txd_q;

  assign start_ok = (32'(count_i) >= wm_bytes(wm_code_i)) || (frames_i != '0);
  // empty on a byte boundary while the frame is live
  assign underrun = (state_q == TX_SEND) && !nib_hi_q && (count_i == '0);
  assign pop_o    = (state_q == TX_SEND) && nib_hi_q;
  assign done_o   = pop_o && head_last_i;
  assign flush_o  = (state_q == TX_FLUSH) || underrun;
  assign underrun_o = underrun;

  always_comb begin
    state_d = state_q;
    case (state_q)
      TX_IDLE:  if (start_ok) state_d = TX_SEND;
      TX_SEND: begin
        if (underrun)    state_d = (wr_fire_i && wr_last_i) ? TX_IDLE : TX_FLUSH;
        else if (done_o) state_d = TX_IDLE;
      end
      TX_FLUSH: if (wr_fire_i && wr_last_i) state_d = TX_IDLE;
      default:  state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= TX_IDLE;
      nib_hi_q <= 1'b0;
      txen_q   <= 1'b0;
      txer_q   <= 1'b0;
      txd_q    <= '0;
    end else begin
      state_q  <= state_d;
      nib_hi_q <= (state_q == TX_SEND) && !underrun && !nib_hi_q;
      txen_q   <= (state_q == TX_SEND);
      txer_q   <= underrun;
      if (state_q != TX_SEND || underrun) txd_q <= '0;
      else txd_q <= nib_hi_q ? head_i[7:4] : head_i[3:0];
    end
  end

  assign txd_o  = txd_q;
  assign txen_o = txen_q;
  assign txer_o = txer_q;
endmodule

// File: rtl/txwm_regs.sv
module txwm_regs
  import txwm_pkg::*;
#(
  parameter int REG_W   = 8,
  parameter int BW      = 8,
  parameter int BND_RST = 'h40,
  parameter int BND_MIN = 'h48,
  parameter int BND_MAX = 'h80
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [EVT_W-1:0] evt_set_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [EVT_W-1:0] evt_o,
  output logic [1:0]       wm_o,
  output logic [BW-1:0]    bound_o,
  output logic             irq_o
);
  logic [EVT_W-1:0] evt_q, mask_q, evt_clr;
  logic [1:0]       wm_q;
  logic [BW-1:0]    bound_q, bound_wr;

  assign evt_clr = (we_i && addr_i == A_EVT) ? wdata_i[EVT_W-1:0] : '0;

  always_comb begin
    if (int'(wdata_i) < BND_MIN)      bound_wr = BW'(BND_MIN);
    else if (int'(wdata_i) > BND_MAX) bound_wr = BW'(BND_MAX);
    else                              bound_wr = BW'(wdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q   <= '0;
      mask_q  <= '0;
      wm_q    <= '0;
      bound_q <= BW'(BND_RST);
    end else begin
      evt_q <= (evt_q & ~evt_clr) | evt_set_i;
      if (we_i && addr_i == A_MASK) mask_q  <= wdata_i[EVT_W-1:0];
      if (we_i && addr_i == A_WMRK) wm_q    <= wdata_i[1:0];
      if (we_i && addr_i == A_BND)  bound_q <= bound_wr;
    end
  end

  always_comb begin
    case (addr_i)
      A_EVT:   rdata_o = REG_W'(evt_q);
      A_MASK:  rdata_o = REG_W'(mask_q);
      A_WMRK:  rdata_o = REG_W'(wm_q);
      default: rdata_o = REG_W'(bound_q);
    endcase
  end

  assign evt_o   = evt_q;
  assign wm_o    = wm_q;
  assign bound_o = bound_q;
  assign irq_o   = |(evt_q & mask_q);
endmodule

// File: rtl/tx_wm_fifo.sv
module tx_wm_fifo
  import txwm_pkg::*;
#(
  parameter int RAM_BYTES = 512,
  parameter int DATA_W    = 32,
  parameter int REG_W     = 8,
  parameter int BND_MIN   = 'h48,
  localparam int LANES   = DATA_W / 8,
  localparam int NBW     = $clog2(LANES),
  localparam int NW      = $clog2(LANES + 1),
  localparam int CW      = $clog2(RAM_BYTES + 1),
  localparam int BND_MAX = RAM_BYTES / LANES,
  localparam int BND_RST = BND_MAX / 2,
  localparam int BW      = $clog2(BND_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_last_i,
  input  logic [NBW-1:0]    wr_nb_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic [3:0]        mii_txd_o,
  output logic              mii_txen_o,
  output logic              mii_txer_o,
  output logic              irq_o
);
  logic [CW-1:0]    count_w, frames_w, cap_w;
  logic [7:0]       head_w;
  logic             head_last_w, pop_w, flush_w, underrun_w, done_w;
  logic             space_ok, wr_fire, push_w;
  logic [NW-1:0]    push_n;
  logic [1:0]       wm_w;
  logic [BW-1:0]    bound_w;
  logic [EVT_W-1:0] evt_w, evt_set;

  // transmit region in bytes
  assign cap_w    = CW'(32'(bound_w) * LANES);
  assign space_ok = (32'(count_w) + LANES) <= 32'(cap_w);
  assign wr_ready_o = flush_w || space_ok;
  assign wr_fire  = wr_valid_i && wr_ready_o;
  assign push_w   = wr_fire && !flush_w;
  assign push_n   = wr_last_i ? NW'(wr_nb_i) + NW'(1) : NW'(LANES);

  always_comb begin
    evt_set = '0;
    evt_set[EVT_UNDERRUN] = underrun_w;
    evt_set[EVT_DONE]     = done_w;
  end

  txwm_store #(.RAM_BYTES(RAM_BYTES), .LANES(LANES)) u_store (
    .clk_i, .rst_ni,
    .push_i(push_w), .push_data_i(wr_data_i), .push_n_i(push_n),
    .push_last_i(wr_last_i), .pop_i(pop_w),
    .head_o(head_w), .head_last_o(head_last_w),
    .count_o(count_w), .frames_o(frames_w)
  );

  txwm_mii_tx #(.CW(CW)) u_tx (
    .clk_i, .rst_ni,
    .wm_code_i(wm_w), .count_i(count_w), .frames_i(frames_w),
    .head_i(head_w), .head_last_i(head_last_w),
    .wr_fire_i(wr_fire), .wr_last_i(wr_last_i),
    .pop_o(pop_w), .flush_o(flush_w), .underrun_o(underrun_w), .done_o(done_w),
    .txd_o(mii_txd_o), .txen_o(mii_txen_o), .txer_o(mii_txer_o)
  );

  txwm_regs #(
    .REG_W(REG_W), .BW(BW), .BND_RST(BND_RST), .BND_MIN(BND_MIN), .BND_MAX(BND_MAX)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .evt_set_i(evt_set), .rdata_o(reg_rdata_o), .evt_o(evt_w),
    .wm_o(wm_w), .bound_o(bound_w), .irq_o(irq_o)
  );
endmodule

// File: rtl/tx_wm_fifo_chk.sv
module tx_wm_fifo_chk
  import txwm_pkg::*;
#(
  parameter int CW = 10,
  parameter int BW = 8,
  parameter int BND_MIN = 'h48
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mii_txen_o,
  input logic             mii_txer_o,
  input logic             reg_we_i,
  input logic [1:0]       reg_addr_i,
  input logic             clr_bit0,
  input logic [EVT_W-1:0] evt,
  input logic [CW-1:0]    count,
  input logic [CW-1:0]    cap,
  input logic [BW-1:0]    bound
);
  assert_txer_in_frame_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mii_txer_o |-> mii_txen_o);

  assert_underrun_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mii_txer_o |-> evt[EVT_UNDERRUN]);

  assert_evt_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt[EVT_UNDERRUN] && !(reg_we_i && reg_addr_i == A_EVT && clr_bit0)) |=> evt[EVT_UNDERRUN]);

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= cap);

  assert_bound_clamp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_BND) |=> (32'(bound) >= BND_MIN));
endmodule

bind tx_wm_fifo tx_wm_fifo_chk #(.CW(CW), .BW(BW), .BND_MIN(BND_MIN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .mii_txen_o(mii_txen_o), .mii_txer_o(mii_txer_o),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .clr_bit0(reg_wdata_i[0]),
  .evt(evt_w), .count(count_w), .cap(cap_w), .bound(bound_w)
);

// File: tb/tx_wm_fifo_tb.sv
module tx_wm_fifo_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, wr_last = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  wr_nb = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        wr_ready_o, mii_txen_o, mii_txer_o, irq_o;
  logic [7:0]  reg_rdata_o;
  logic [3:0]  mii_txd_o;

  int checks = 0, fails = 0;
  bit stalled = 0, ended = 0;
  logic [4:0] exp_q[$];

  always #10 clk = ~clk;

  tx_wm_fifo u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready_o), .wr_data_i(wr_data),
    .wr_last_i(wr_last), .wr_nb_i(wr_nb),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata_o),
    .mii_txd_o(mii_txd_o), .mii_txen_o(mii_txen_o), .mii_txer_o(mii_txer_o),
    .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: every live nibble must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      if (mii_txer_o && !mii_txen_o) chk(1'b0, "R5 error outside frame", 1, 0);
      if (mii_txen_o) begin
        if (exp_q.size() == 0) chk(1'b0, "R2/R6 unexpected nibble", {mii_txer_o, mii_txd_o}, 0);
        else begin
          logic [4:0] e;
          e = exp_q.pop_front();
          chk({mii_txer_o, mii_txd_o} == e, "R2/R5 nibble stream", {mii_txer_o, mii_txd_o}, e);
        end
      end
    end
  end

  task automatic exp_frame(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'(seed + i);
      exp_q.push_back({1'b0, b[3:0]});
      exp_q.push_back({1'b0, b[7:4]});
    end
  endtask

  task automatic push(input logic [31:0] d, input bit last, input logic [1:0] nb);
    wr_valid = 1'b1; wr_data = d; wr_last = last; wr_nb = nb;
    while (!wr_ready_o) begin stalled = 1; @(negedge clk); end
    @(negedge clk);
    wr_valid = 1'b0; wr_last = 1'b0;
  endtask

  // bytes [from,to) of frame with byte i = seed+i; from is word aligned
  task automatic write_bytes(input int seed, input int from, input int to, input bit end_frame);
    for (int w = from; w < to; w += 4) begin
      logic [31:0] d;
      int nb;
      nb = (to - w > 4) ? 4 : to - w;
      d = '0;
      for (int k = 0; k < nb; k++) d[8*k +: 8] = 8'(seed + w + k);
      push(d, end_frame && (w + 4 >= to), 2'(nb - 1));
    end
  endtask

  task automatic wait_drain();
    int t = 0;
    while ((exp_q.size() != 0 || mii_txen_o) && t < 5000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic regw(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic regr(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic finish_test();
    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_test();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!mii_txen_o && !mii_txer_o, "R1 line idle", mii_txen_o, 0);
    chk(!irq_o, "R1 irq", irq_o, 0);
    chk(wr_ready_o, "R1 ready", wr_ready_o, 1);
    regr(2'd0, v); chk(v == 8'h00, "R1 event reg", v, 0);
    regr(2'd2, v); chk(v == 8'h00, "R1 watermark reg", v, 0);
    regr(2'd3, v); chk(v == 8'h40, "R1 boundary reg", v, 8'h40);

    // R4 short frame below watermark, R10 done event
    exp_frame(10, 8'h30);
    write_bytes(8'h30, 0, 10, 1);
    wait_drain();
    chk(exp_q.size() == 0, "R4 short frame sent", exp_q.size(), 0);
    regr(2'd0, v); chk(v == 8'h02, "R10 done event", v, 2);

    // R3 watermark codes 01/10/11
    for (int c = 1; c < 4; c++) begin
      int thr, seed;
      thr  = (c == 1) ? 64 : (c == 2) ? 128 : 192;
      seed = 16 * c;
      regw(2'd2, 8'(c));
      exp_frame(thr + 8, seed);
      write_bytes(seed, 0, thr - 4, 0);
      repeat (12) @(negedge clk);
      chk(!mii_txen_o, "R3 held below watermark", mii_txen_o, 0);
      write_bytes(seed, thr - 4, thr, 0);
      repeat (3) @(negedge clk);
      chk(mii_txen_o, "R3 start at watermark", mii_txen_o, 1);
      write_bytes(seed, thr, thr + 8, 1);
      wait_drain();
      chk(exp_q.size() == 0, "R3 frame complete", exp_q.size(), 0);
    end

    // R9 boundary clamping and back-pressure
    regw(2'd3, 8'h20); regr(2'd3, v); chk(v == 8'h48, "R9 clamp low", v, 8'h48);
    regw(2'd3, 8'hFF); regr(2'd3, v); chk(v == 8'h80, "R9 clamp high", v, 8'h80);
    regw(2'd3, 8'h60); regr(2'd3, v); chk(v == 8'h60, "R9 in range", v, 8'h60);
    regw(2'd3, 8'h80);
    regw(2'd2, 8'd3);
    stalled = 0;
    exp_frame(400, 8'h11);
    write_bytes(8'h11, 0, 400, 1);
    chk(!stalled, "R9 wide region never stalls", stalled, 0);
    wait_drain();
    regw(2'd3, 8'h40); regr(2'd3, v); chk(v == 8'h48, "R9 reset value rejected", v, 8'h48);
    stalled = 0;
    exp_frame(400, 8'h22);
    write_bytes(8'h22, 0, 400, 1);
    chk(stalled, "R9 narrow region stalls", stalled, 1);
    wait_drain();
    chk(exp_q.size() == 0, "R9 stalled frame intact", exp_q.size(), 0);

    // R5 underrun, R8 irq, R6 drop of remainder
    regw(2'd0, 8'h03);
    regw(2'd1, 8'h01);
    regw(2'd2, 8'h00);
    exp_frame(64, 8'h50);
    exp_q.push_back(5'h10);
    write_bytes(8'h50, 0, 64, 0);
    wait_drain();
    chk(exp_q.size() == 0, "R5 error nibble seen", exp_q.size(), 0);
    regr(2'd0, v); chk(v == 8'h01, "R5 underrun event", v, 1);
    chk(irq_o, "R8 irq on masked underrun", irq_o, 1);
    write_bytes(8'h50, 64, 100, 1);
    repeat (20) @(negedge clk);
    chk(!mii_txen_o, "R6 remainder dropped", mii_txen_o, 0);
    exp_frame(12, 8'h70);
    write_bytes(8'h70, 0, 12, 1);
    wait_drain();
    chk(exp_q.size() == 0, "R6 next frame normal", exp_q.size(), 0);
    regr(2'd0, v); chk(v == 8'h03, "R10 both events", v, 3);

    // R7 write-one-to-clear, R8 mask
    regw(2'd0, 8'h01); regr(2'd0, v); chk(v == 8'h02, "R7 clear one bit", v, 2);
    regw(2'd0, 8'h00); regr(2'd0, v); chk(v == 8'h02, "R7 zero write no effect", v, 2);
    chk(!irq_o, "R8 unmasked bit no irq", irq_o, 0);
    regw(2'd1, 8'h02);
    #1 chk(irq_o, "R8 irq on masked done", irq_o, 1);
    regw(2'd0, 8'h02); regr(2'd0, v); chk(v == 8'h00, "R7 cleared", v, 0);
    chk(!irq_o, "R8 irq drops", irq_o, 0);

    finish_test();
  end
endmodule